// File: doc/BRIEF.md
# Packed Lane Saturating Add/Subtract Unit

This unit performs lane-parallel arithmetic on a 32-bit word. The word is split into four 8-bit lanes or two 16-bit lanes. Each lane is computed on its own, and no carry crosses from one lane into the next. The operations are add, subtract, halving add, halving subtract and absolute value. Each operation reads its lanes as either signed or unsigned values.

A caller places two operand words and the operation controls on the inputs and pulses `start`. One clock later the packed result appears on `result`, together with a one-cycle `done` pulse. The unit also keeps an overflow indication. Add, subtract and absolute value set it whenever any lane leaves its range. Only reset clears it, so software can run a whole sequence of operations and check once at the end whether any lane went out of range.

Top module: `lane_arith_unit`

## Requirements
- R1: With `fmt`=0 the word holds four 8-bit lanes, lane i at bits [8i+7:8i]. With `fmt`=1 it holds two 16-bit lanes, lane i at bits [16i+15:16i]. Every lane is computed independently of the other lanes.
- R2: The `op` codes are 0 add, 1 subtract, 2 halving add, 3 halving subtract and 4 absolute value. Codes 5 to 7 give a zero result and never raise overflow.
- R3: With `sgn`=1 each lane of `opa` and `opb` is sign-extended before the arithmetic. With `sgn`=0 each lane is zero-extended.
- R4: For add and subtract with `sat_en`=1, a lane result above the lane maximum becomes the maximum and one below the lane minimum becomes the minimum. The limits are signed (-2^(w-1) to 2^(w-1)-1) when `sgn`=1 and unsigned (0 to 2^w-1) when `sgn`=0.
- R5: For add and subtract with `sat_en`=0, the lane result wraps to the lane width. A lane that left its range still raises overflow.
- R6: Halving add and subtract give floor((a±b+k)/2), computed without loss of precision, where k is 1 when `rnd_en`=1 and 0 otherwise. These operations never raise overflow.
- R7: For absolute value with `sgn`=1, a lane holding the most negative value returns the lane maximum and raises overflow. Other negative lanes are negated, and non-negative lanes pass through. With `sgn`=0 the lanes pass through unchanged and overflow is not raised.
- R8: `ovf_sticky` goes to 1 on the clock edge that captures an operation in which any lane raised overflow. Only reset clears it. `sat_en` has no effect on halving or absolute value, and `rnd_en` has no effect on add, subtract or absolute value.
- R9: `result` and `done` are updated on the clock edge at which `start` is sampled high. `done` is high only for the cycle that follows a start. `result` keeps its value in cycles that follow no start.
- R10: While `rst_n` is low, `result`, `done` and `ovf_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the operation on this edge |
| opa | input | 32 | First operand word |
| opb | input | 32 | Second operand word (not used by absolute value) |
| fmt | input | 1 | Lane format: 0 = four 8-bit lanes, 1 = two 16-bit lanes |
| op | input | 3 | Operation code |
| sgn | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| sat_en | input | 1 | Saturate add/subtract |
| rnd_en | input | 1 | Round halving operations |
| result | output | 32 | Registered packed result |
| done | output | 1 | Result valid pulse |
| ovf_sticky | output | 1 | Sticky lane overflow indication |

## Verification
The bench builds the unit with its default parameters: a 32-bit word and 8-bit narrow lanes, which give 16-bit wide lanes. At these sizes both lane formats, and every signed and unsigned limit of both, can be reached by driving lane values drawn from the set 0x00, 0x01, 0x7F, 0x80 and 0xFF. Among the cases this reaches are the most-negative absolute value, unsigned underflow on subtract, and halving sums that need a bit above the lane width. The sticky flag is checked across a reset in the middle of the run, and across a phase that uses only halving operations, whose extreme operands must not set it.

// File: rtl/lane_arith_unit.sv
module lane_arith_unit #(
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic              fmt,
  input  logic [2:0]        op,
  input  logic              sgn,
  input  logic              sat_en,
  input  logic              rnd_en,
  output logic [WORD_W-1:0] result,
  output logic              done,
  output logic              ovf_sticky
);
  localparam int WIDE_W   = 2 * NARROW_W;
  localparam int N_NARROW = WORD_W / NARROW_W;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_HADD = 3'd2,
                         OP_HSUB = 3'd3, OP_ABS = 3'd4;

  logic [WORD_W-1:0]   fres [2];
  logic [N_NARROW-1:0] fovf [2];

  for (genvar gf = 0; gf < 2; gf++) begin : g_fmt
    localparam int LW = (gf == 1) ? WIDE_W : NARROW_W;
    localparam int NL = WORD_W / LW;
    localparam int E  = LW + 2;
    logic [NL-1:0] ov;

    for (genvar i = 0; i < NL; i++) begin : g_lane
      logic [LW-1:0] la, lb, lmax, lmin, clampv, addsub_v, abs_v, lane_v;
      logic [E-1:0]  xa, xb, rng, half;
      logic          oor, amin, lane_o;

      assign la   = opa[i*LW +: LW];
      assign lb   = opb[i*LW +: LW];
      assign xa   = sgn ? {{2{la[LW-1]}}, la} : {2'b00, la};
      assign xb   = sgn ? {{2{lb[LW-1]}}, lb} : {2'b00, lb};
      assign rng  = (op == OP_SUB) ? xa - xb : xa + xb;
      assign half = ((op == OP_HSUB) ? xa - xb : xa + xb) + E'(rnd_en);

      assign lmax = sgn ? {1'b0, {(LW-1){1'b1}}} : {LW{1'b1}};
      assign lmin = sgn ? {1'b1, {(LW-1){1'b0}}} : '0;
      assign oor  = sgn ? (rng[E-1:LW-1] != '0 && rng[E-1:LW-1] != '1)
                        : (rng[E-1] | rng[LW]);
      assign clampv   = rng[E-1] ? lmin : lmax;
      assign addsub_v = (sat_en && oor) ? clampv : rng[LW-1:0];

      assign amin  = sgn && (la == {1'b1, {(LW-1){1'b0}}});
      assign abs_v = amin ? lmax : (sgn && la[LW-1]) ? (~la + LW'(1)) : la;

      always_comb begin
        lane_v = '0;
        lane_o = 1'b0;
        case (op)
          OP_ADD, OP_SUB:   begin lane_v = addsub_v; lane_o = oor; end
          OP_HADD, OP_HSUB: lane_v = half[LW:1];
          OP_ABS:           begin lane_v = abs_v; lane_o = amin; end
          default:          ;
        endcase
      end

      assign fres[gf][i*LW +: LW] = lane_v;
      assign ov[i] = lane_o;
    end

    assign fovf[gf] = N_NARROW'(ov);
  end

  logic [WORD_W-1:0] cur_res;
  logic              cur_ovf;
  assign cur_res = fmt ? fres[1] : fres[0];
  assign cur_ovf = |(fmt ? fovf[1] : fovf[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result     <= '0;
      done       <= 1'b0;
      ovf_sticky <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result     <= cur_res;
        ovf_sticky <= ovf_sticky | cur_ovf;
      end
    end
  end
endmodule

// File: rtl/lane_arith_chk.sv
module lane_arith_chk #(
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [WORD_W-1:0] opa,
  input logic              fmt,
  input logic [2:0]        op,
  input logic              sgn,
  input logic              sat_en,
  input logic [WORD_W-1:0] result,
  input logic              done,
  input logic              ovf_sticky
);
  // R9
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!done && $stable(result)));
  // R8
  sticky_never_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ovf_sticky));
  // R6
  halving_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op == 3'd2 || op == 3'd3) && !ovf_sticky) |=> !ovf_sticky);
  // R4
  sat_uadd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sat_en && op == 3'd0 && !sgn && !fmt)
      |=> result[NARROW_W-1:0] >= $past(opa[NARROW_W-1:0]));
  // R7
  abs_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 3'd4 && sgn && !fmt) |=> !result[NARROW_W-1]);
endmodule

bind lane_arith_unit lane_arith_chk #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .fmt(fmt), .op(op),
  .sgn(sgn), .sat_en(sat_en), .result(result), .done(done),
  .ovf_sticky(ovf_sticky)
);

// File: tb/sim_lane_arith_unit.sv
module sim_lane_arith_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        fmt = 1'b0, sgn = 1'b0, sat_en = 1'b0, rnd_en = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] result;
  logic        done, ovf_sticky;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [31:0] exp_res = '0;
  logic        exp_done = 1'b0, exp_sticky = 1'b0;
  string       res_tag = "R10";

  always #5 clk = ~clk;

  lane_arith_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb), .fmt(fmt),
    .op(op), .sgn(sgn), .sat_en(sat_en), .rnd_en(rnd_en), .result(result),
    .done(done), .ovf_sticky(ovf_sticky)
  );

  function automatic logic [32:0] ref_op(logic [31:0] a, logic [31:0] b, logic f,
                                         logic [2:0] o, logic s, logic sat, logic rnd);
    int w = f ? 16 : 8;
    int n = 32 / w;
    logic [31:0] r = '0;
    logic ov = 1'b0;
    for (int i = 0; i < n; i++) begin
      longint m = (longint'(1) << w) - 1;
      longint x = (longint'(a) >> (i * w)) & m;
      longint y = (longint'(b) >> (i * w)) & m;
      longint hi = s ? (longint'(1) << (w - 1)) - 1 : m;
      longint lo = s ? -(longint'(1) << (w - 1)) : 0;
      longint v = 0;
      if (s && x > hi) x = x - (m + 1);
      if (s && y > hi) y = y - (m + 1);
      case (o)
        3'd0, 3'd1: begin
          v = (o == 3'd0) ? x + y : x - y;
          if (v > hi) begin ov = 1'b1; if (sat) v = hi; end
          else if (v < lo) begin ov = 1'b1; if (sat) v = lo; end
        end
        3'd2, 3'd3: v = (((o == 3'd2) ? x + y : x - y) + longint'(rnd)) >>> 1;
        3'd4: begin
          if (s && x == lo) begin v = hi; ov = 1'b1; end
          else if (x < 0) v = -x;
          else v = x;
        end
        default: v = 0;
      endcase
      r = r | 32'((v & m) << (i * w));
    end
    return {ov, r};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk(res_tag, result, exp_res);
    chk("R9 done", {31'b0, done}, {31'b0, exp_done});
    chk("R8 sticky", {31'b0, ovf_sticky}, {31'b0, exp_sticky});
  endtask

  task automatic step(logic st, logic [2:0] o, logic f, logic s, logic sat,
                      logic rnd, logic [31:0] a, logic [31:0] b);
    logic [32:0] m;
    check_outputs();
    start = st; op = o; fmt = f; sgn = s; sat_en = sat; rnd_en = rnd;
    opa = a; opb = b;
    exp_done = st;
    if (st) begin
      m = ref_op(a, b, f, o, s, sat, rnd);
      exp_res = m[31:0];
      exp_sticky = exp_sticky | m[32];
      if (o <= 3'd1) res_tag = sat ? "R4/R1/R3" : "R5/R1/R3";
      else if (o <= 3'd3) res_tag = "R6/R1/R3";
      else if (o == 3'd4) res_tag = "R7/R1/R3";
      else res_tag = "R2";
    end else begin
      res_tag = "R9 hold";
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    exp_res = '0; exp_done = 1'b0; exp_sticky = 1'b0; res_tag = "R10";
    check_outputs();
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] v;
    case ($urandom % 4)
      0: v = $urandom;
      1: v = '0;
      default: begin
        v = '0;
        for (int k = 0; k < 4; k++) begin
          logic [7:0] bv;
          case ($urandom % 5)
            0: bv = 8'h00; 1: bv = 8'h01; 2: bv = 8'h7F; 3: bv = 8'h80;
            default: bv = 8'hFF;
          endcase
          v[k*8 +: 8] = bv;
        end
      end
    endcase
    return v;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();   // R10
    // R6: extreme halving operands, flag must stay clear
    step(1, 3'd2, 0, 1, 1, 0, 32'h80808080, 32'h80808080);
    step(1, 3'd3, 0, 0, 0, 1, 32'h00000000, 32'hFFFFFFFF);
    step(1, 3'd2, 1, 0, 0, 1, 32'hFFFFFFFF, 32'hFFFF0001);
    step(0, 3'd0, 0, 0, 0, 0, 32'h12345678, 32'h9ABCDEF0);
    // R2: reserved code
    step(1, 3'd6, 0, 0, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    // R4: unsigned saturating add, byte lanes
    step(1, 3'd0, 0, 0, 1, 0, 32'hFF7F0080, 32'h01010180);
    // R5: wrapping signed add, halfword lanes
    step(1, 3'd0, 1, 1, 0, 0, 32'h7FFF8000, 32'h0001FFFF);
    step(1, 3'd1, 0, 0, 1, 0, 32'h00010203, 32'h01010101);
    // R7: abs with most negative halfword
    step(1, 3'd4, 1, 1, 0, 0, 32'h8000FFFE, 32'h0);
    step(1, 3'd4, 0, 0, 0, 0, 32'h80FF7F00, 32'h0);
    step(0, 3'd0, 0, 0, 0, 0, 32'h0, 32'h0);
    // R8: mid-run reset clears sticky, then halving-only random phase
    do_reset();
    for (int t = 0; t < 1000; t++)
      step(1'($urandom % 2), 3'(2 + $urandom % 2), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), pick(), pick());
    do_reset();
    for (int t = 0; t < 4000; t++)
      step(1'(($urandom % 4) != 0), 3'($urandom % 8), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), pick(), pick());
    step(0, 3'd0, 0, 0, 0, 0, 32'h0, 32'h0);
    check_outputs();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule